// File: doc/BRIEF.md
# TDM Timeslot Serial Receiver

This block takes a framed time-division serial stream, one data bit per clock, and turns it back into bytes tagged with their timeslot. A frame is 32 timeslots of 8 bits (256 bit times). A local bit counter runs from 0 to 255 and is forced back into step with the sender by a frame marker input. The sender raises that marker during the last bit time of each frame. Incoming bits enter a serial-in parallel-out shift register, most significant bit first.

When the low bits of the counter show that the final bit of a timeslot has just been taken in, the complete byte is copied into a holding register. The timeslot number is copied with it, and a one-clock valid strobe is raised. The holding register keeps the byte steady for a whole timeslot while the next byte shifts in. Downstream logic can therefore pick it up at any point in that window.

Top module: `tdm_slot_rx`

## Requirements
- R1: While reset is asserted, and until the first byte is delivered, `rx_byte` and `rx_slot` read zero and `byte_valid` is low.
- R2: No `byte_valid` pulse is produced before the first clock edge at which `frame_sync` is sampled high after reset. This includes the edge that carries that first `frame_sync`.
- R3: The bit sampled on the edge after a `frame_sync` edge is bit 0 of timeslot 0; `frame_sync` forces the counter to zero.
- R4: Bits are assembled most significant bit first: the first bit of a timeslot lands in `rx_byte[7]` and the eighth in `rx_byte[0]`.
- R5: Once aligned, `byte_valid` is high for exactly one cycle after every eighth bit. It rises on the same edge that loads `rx_byte`.
- R6: `rx_byte` and `rx_slot` change only on an edge that also raises `byte_valid`, and hold their value between pulses.
- R7: `rx_slot` is the timeslot number (counter bits 7:3) of the byte delivered with it. The counter wraps from 255 to 0 with no `frame_sync`. A `frame_sync` at count 255 still delivers the timeslot-31 byte.
- R8: A `frame_sync` at any count other than 255 realigns the counter and discards the partial byte. No pulse results, even when the count sits on bit 7 of a slot. The next eight bits are delivered as timeslot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_data | input | 1 | Serial data bit |
| frame_sync | input | 1 | High during the last bit time of a frame |
| rx_byte | output | 8 | Last completed byte (holding register) |
| rx_slot | output | 5 | Timeslot number of `rx_byte` |
| byte_valid | output | 1 | One-cycle strobe when `rx_byte` is loaded |

## Verification
The hardest case to reach from the ports is a frame marker that lands exactly on bit 7 of a slot other than 31. The bit-field decode then reports a finished byte, yet the byte must be thrown away. The stimulus first locks to a frame and lets it wrap once on its own. It then sends seven bits of slot 1 and raises the marker on the eighth. The check requires that no pulse appears, that the held byte is unchanged, and that the next byte arrives tagged as slot 0. A second realignment in the middle of a slot and the marker on count 255 cover the neighbouring cases.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  // Default frame geometry; both must be powers of two so the counter
  // splits into a slot field and a bit field.
  localparam int unsigned DEF_SLOTS = 32;
  localparam int unsigned DEF_BITS  = 8;
endpackage

// File: rtl/tdm_rx_rst_sync.sv
module tdm_rx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/tdm_rx_slot_cnt.sv
module tdm_rx_slot_cnt #(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned BITS  = 8,
  localparam int unsigned CNT_W  = $clog2(SLOTS * BITS),
  localparam int unsigned BIT_W  = $clog2(BITS),
  localparam int unsigned SLOT_W = CNT_W - BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  output logic [CNT_W-1:0]  cnt,
  output logic              locked,
  output logic              word_done,
  output logic [SLOT_W-1:0] done_slot
);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(SLOTS * BITS - 1);
  localparam logic [BIT_W-1:0] BIT_END = BIT_W'(BITS - 1);

  logic [CNT_W-1:0] cnt_d;
  logic             locked_d;
  logic             at_slot_end;
  logic             misaligned;

  always_comb begin
    at_slot_end = (cnt[BIT_W-1:0] == BIT_END);
    misaligned  = frame_sync && (cnt != LAST);
    if (frame_sync || cnt == LAST) cnt_d = '0;
    else                           cnt_d = cnt + 1'b1;
    locked_d  = locked | frame_sync;
    word_done = locked && at_slot_end && !misaligned;
    done_slot = cnt[CNT_W-1:BIT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else begin
      cnt    <= cnt_d;
      locked <= locked_d;
    end
  end
endmodule

// File: rtl/tdm_rx_sipo.sv
module tdm_rx_sipo #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_in,
  output logic [BITS-1:0] word
);
  logic [BITS-2:0] sr_q;
  logic [BITS-2:0] sr_d;

  always_comb begin
    word = {sr_q, ser_in};
    sr_d = word[BITS-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/tdm_rx_hold.sv
module tdm_rx_hold #(
  parameter int unsigned BITS   = 8,
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BITS-1:0]   word_in,
  input  logic [SLOT_W-1:0] slot_in,
  output logic [BITS-1:0]   word_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic              valid_q
);
  logic [BITS-1:0]   word_d;
  logic [SLOT_W-1:0] slot_d;

  always_comb begin
    word_d = word_q;
    slot_d = slot_q;
    if (load) begin
      word_d = word_in;
      slot_d = slot_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      slot_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      slot_q  <= slot_d;
      valid_q <= load;
    end
  end
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import tdm_rx_pkg::*;
#(
  parameter int unsigned SLOTS = DEF_SLOTS,
  parameter int unsigned BITS  = DEF_BITS,
  localparam int unsigned CNT_W  = $clog2(SLOTS * BITS),
  localparam int unsigned BIT_W  = $clog2(BITS),
  localparam int unsigned SLOT_W = CNT_W - BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data,
  input  logic              frame_sync,
  output logic [BITS-1:0]   rx_byte,
  output logic [SLOT_W-1:0] rx_slot,
  output logic              byte_valid
);
  logic              rst_int_n;
  logic [CNT_W-1:0]  cnt_q;
  logic              locked_q;
  logic              word_done;
  logic [SLOT_W-1:0] done_slot;
  logic [BITS-1:0]   word_now;

  tdm_rx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  tdm_rx_slot_cnt #(.SLOTS(SLOTS), .BITS(BITS)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .frame_sync (frame_sync),
    .cnt        (cnt_q),
    .locked     (locked_q),
    .word_done  (word_done),
    .done_slot  (done_slot)
  );

  tdm_rx_sipo #(.BITS(BITS)) u_sipo (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ser_in (ser_data),
    .word   (word_now)
  );

  tdm_rx_hold #(.BITS(BITS), .SLOT_W(SLOT_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (word_done),
    .word_in (word_now),
    .slot_in (done_slot),
    .word_q  (rx_byte),
    .slot_q  (rx_slot),
    .valid_q (byte_valid)
  );
endmodule

// File: rtl/tdm_slot_rx_chk.sv
module tdm_slot_rx_chk #(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned BITS  = 8,
  localparam int unsigned CNT_W  = $clog2(SLOTS * BITS),
  localparam int unsigned BIT_W  = $clog2(BITS),
  localparam int unsigned SLOT_W = CNT_W - BIT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_sync,
  input logic [CNT_W-1:0]  cnt,
  input logic              locked,
  input logic              byte_valid,
  input logic [BITS-1:0]   rx_byte,
  input logic [SLOT_W-1:0] rx_slot
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS * BITS - 1);

  assert_quiet_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !byte_valid);

  assert_sync_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (cnt == '0));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  assert_hold_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |-> ($stable(rx_byte) && $stable(rx_slot)));

  assert_slot_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (rx_slot == $past(cnt[CNT_W-1:BIT_W])));

  assert_free_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == LAST && !frame_sync) |=> (cnt == '0));

  assert_drop_partial_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && cnt != LAST) |=> !byte_valid);
endmodule

bind tdm_slot_rx tdm_slot_rx_chk #(.SLOTS(SLOTS), .BITS(BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_sync (frame_sync),
  .cnt        (cnt_q),
  .locked     (locked_q),
  .byte_valid (byte_valid),
  .rx_byte    (rx_byte),
  .rx_slot    (rx_slot)
);

// File: tb/tb_tdm_slot_rx.sv
module tb_tdm_slot_rx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_data;
  logic       frame_sync;
  logic [7:0] rx_byte;
  logic [4:0] rx_slot;
  logic       byte_valid;

  int   n_cmp = 0;
  int   n_bad = 0;
  logic done  = 1'b0;
  logic [7:0] hold_b = 8'h00;
  logic [4:0] hold_s = 5'd0;

  always #2ns clk = ~clk;

  tdm_slot_rx dut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .frame_sync(frame_sync),
    .rx_byte(rx_byte), .rx_slot(rx_slot), .byte_valid(byte_valid)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic s);
    @(negedge clk);
    ser_data   = b;
    frame_sync = s;
    @(posedge clk);
    #1ns;
  endtask

  // Eight bits MSB first; marker optionally on the eighth bit.
  task automatic send_byte(input logic [7:0] v, input logic sync_last,
                           input logic exp_valid, input logic [4:0] exp_slot,
                           input string req);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step(v[7-i], sync_last && (i == 7));
      if (i < 7 && (byte_valid !== 1'b0 || rx_byte !== hold_b || rx_slot !== hold_s))
        ok = 1'b0;
    end
    check("R6 held byte steady, no pulse mid-slot", 32'(ok), 32'd1);
    if (exp_valid) begin
      check({req, " byte_valid"}, 32'(byte_valid), 32'd1);
      check({req, " rx_byte"}, 32'(rx_byte), 32'(v));
      check({req, " rx_slot"}, 32'(rx_slot), 32'(exp_slot));
      hold_b = v;
      hold_s = exp_slot;
    end else begin
      check({req, " no byte_valid"}, 32'(byte_valid), 32'd0);
      check({req, " rx_byte unchanged"}, 32'(rx_byte), 32'(hold_b));
    end
  endtask

  function automatic logic [7:0] pat(input int s);
    if (s == 0) return 8'h80;
    if (s == 1) return 8'h01;
    return 8'(s * 29 + 7);
  endfunction

  task automatic t_reset;
    rst_n = 1'b0; ser_data = 1'b0; frame_sync = 1'b0;
    repeat (3) @(posedge clk);
    #1ns;
    check("R1 reset byte_valid", 32'(byte_valid), 32'd0);
    check("R1 reset rx_byte", 32'(rx_byte), 32'd0);
    check("R1 reset rx_slot", 32'(rx_slot), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1ns;
    check("R1 after release byte_valid", 32'(byte_valid), 32'd0);
    check("R1 after release rx_byte", 32'(rx_byte), 32'd0);
  endtask

  task automatic t_no_lock;
    for (int k = 0; k < 5; k++) send_byte(8'hA5, 1'b0, 1'b0, 5'd0, "R2 before first marker");
  endtask

  task automatic t_first_frame;
    step(1'b1, 1'b1);
    check("R2 first marker edge no pulse", 32'(byte_valid), 32'd0);
    for (int s = 0; s < 32; s++) begin
      if (s == 0)       send_byte(pat(s), 1'b0, 1'b1, 5'(s), "R3 R4 slot0 MSB first");
      else if (s == 1)  send_byte(pat(s), 1'b0, 1'b1, 5'(s), "R4 slot1 LSB last");
      else if (s == 31) send_byte(pat(s), 1'b1, 1'b1, 5'(s), "R7 marker at count 255");
      else              send_byte(pat(s), 1'b0, 1'b1, 5'(s), "R5 in-frame byte");
    end
  endtask

  task automatic t_wrap;
    for (int s = 0; s < 32; s++)
      send_byte(8'(pat(s) ^ 8'h5A), 1'b0, 1'b1, 5'(s), "R7 free-running frame");
    send_byte(8'hE1, 1'b0, 1'b1, 5'd0, "R7 wrap 255 to 0 without marker");
  endtask

  task automatic t_mid_resync;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    check("R8 mid-slot marker no pulse", 32'(byte_valid), 32'd0);
    send_byte(8'h3C, 1'b0, 1'b1, 5'd0, "R8 realigned to slot0");
  endtask

  task automatic t_bit7_resync;
    send_byte(8'h77, 1'b1, 1'b0, 5'd0, "R8 marker on bit7 of slot1 dropped");
    send_byte(8'hC3, 1'b0, 1'b1, 5'd0, "R8 after drop slot0");
    send_byte(8'h5A, 1'b0, 1'b1, 5'd1, "R8 after drop slot1");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_no_lock();
    t_first_frame();
    t_wrap();
    t_mid_resync();
    t_bit7_resync();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule